// File: doc/BRIEF.md
# I2C status flag unit

This block keeps the status flags of a byte-oriented I2C controller and applies their set and clear rules. The bus engine reports events to it as single-cycle strobes. These events are a start condition generated, an own-address match, a general-call match, a transmitted byte completed, a receive acknowledge clock completed, a stop detected and arbitration lost. The register interface reports single-cycle strobes for a status read, a data read, a data write and a write of the START control bit. Level inputs give the peripheral enable, the interrupt enable and the acknowledge enable. From these the block drives two status bytes, an interrupt request, and a request to hold SCL low.

Most flags are cleared by software in two steps. Software first reads the status register and then accesses the data register. A one-bit armed latch records the status read, and the next data access of either kind consumes the latch. The flags that need the two-step sequence clear only on an armed access.

The design has three small state machines. The armed latch moves between `ARM_IDLE` and `ARM_READY`: a status read takes it to `ARM_READY`, and a data access without a status read in the same cycle returns it to `ARM_IDLE`. The role machine moves between `ROLE_SLAVE` and `ROLE_MASTER`: a START write takes it to `ROLE_MASTER`, and a stop or an arbitration loss returns it to `ROLE_SLAVE`. The byte-done machine holds `BTF_CLEAR`, `BTF_RX` or `BTF_TX`. A receive completion with acknowledge enabled enters `BTF_RX`, and a transmit completion enters `BTF_TX`. An armed data read leaves `BTF_RX` and an armed data write leaves `BTF_TX`, in both cases to `BTF_CLEAR`. When the peripheral is disabled, all three machines return to their first state.

Top module: `i2c_stat_flags`

## Requirements
- R1: After reset, `stat1` and `stat2` are 00h, and `irq` and `scl_hold` are 0.
- R2: The start flag (`stat1` bit 0) is 1 in the cycle after `ev_start_gen`. A status read followed by a later data write clears it. A data write with no status read before it leaves the flag set.
- R3: The master flag (`stat1` bit 1) is 1 in the cycle after `wr_start`. It returns to 0 in the cycle after `ev_stop` or `ev_arb_lost`.
- R4: The address flag (`stat1` bit 2) sets after `ev_addr_match` or `ev_gcall_match`. A general-call match also sets `stat2` bit 0. A status read on its own clears both of these bits.
- R5: The byte-done flag (`stat1` bit 3) sets after `ev_ack_clk_done` only when `ack_en` is 1. When it was set this way, an armed data read clears it and an armed data write does not.
- R6: After `ev_byte_tx_done`, the byte-done flag sets. An armed data write clears it and an armed data read does not.
- R7: A status read arms the latch, and the next data access of either kind disarms it. A further data access with no new status read clears no flag.
- R8: When a set event and a clearing access fall in the same cycle, the flag is 1 afterwards.
- R9: When `en` is 0, all flags and the armed latch are 0 from the next cycle on, and set events are ignored for as long as `en` stays 0.
- R10: `irq` is `ie` AND (start flag OR address flag OR byte-done flag). The master flag alone never raises `irq`.
- R11: `scl_hold` is address flag OR byte-done flag. The start flag alone does not hold SCL.
- R12: `stat2` bits 7:1 always read 0, including bits 7:5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Peripheral enable; 0 clears everything |
| ie | input | 1 | Interrupt enable |
| ack_en | input | 1 | Acknowledge enable for received bytes |
| ev_start_gen | input | 1 | Start condition generated strobe |
| ev_addr_match | input | 1 | Own address matched strobe |
| ev_gcall_match | input | 1 | General call recognised strobe |
| ev_byte_tx_done | input | 1 | Transmitted byte completed strobe |
| ev_ack_clk_done | input | 1 | Receive acknowledge clock completed strobe |
| ev_stop | input | 1 | Stop condition detected strobe |
| ev_arb_lost | input | 1 | Arbitration lost strobe |
| wr_start | input | 1 | Software write of START=1 |
| rd_stat | input | 1 | Status register read strobe |
| rd_data | input | 1 | Data register read strobe |
| wr_data | input | 1 | Data register write strobe |
| stat1 | output | 8 | Status byte 1: bit0 start, bit1 master, bit2 address, bit3 byte done |
| stat2 | output | 8 | Status byte 2: bit0 general call, others 0 |
| irq | output | 1 | Interrupt request |
| scl_hold | output | 1 | Request to hold SCL low |

## Verification
The checker module tests rules that relate one cycle to the next, and it tests them on every cycle. A disable empties both status bytes in the following cycle. A start event, an address event or a START write sets its flag in the following cycle. A status read with no competing set event clears the address flag. The start and byte-done flags hold for as long as no data access occurs.

Some behaviour depends on a history of several accesses, and only the directed scenarios show it. These scenarios test that the armed latch is consumed by one access, and that a receive byte-done ignores a write while a transmit byte-done ignores a read. They also test that a disable forgets an earlier status read, and that set wins over clear when both fall in one cycle.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
    localparam int STAT_W  = 8;
    localparam int SB_BIT  = 0;
    localparam int MSL_BIT = 1;
    localparam int ADM_BIT = 2;
    localparam int BTF_BIT = 3;
    localparam int GC_BIT  = 0;

    typedef enum logic {ARM_IDLE, ARM_READY} arm_state_e;
    typedef enum logic {ROLE_SLAVE, ROLE_MASTER} role_state_e;
    typedef enum logic [1:0] {BTF_CLEAR, BTF_RX, BTF_TX} btf_state_e;
endpackage

// File: rtl/i2c_stat_arm.sv
module i2c_stat_arm
    import i2c_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic rd_stat,
    input  logic data_acc,
    output logic armed
);
    arm_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARM_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARM_IDLE:  if (rd_stat) state_d = ARM_READY;
            ARM_READY: if (data_acc && !rd_stat) state_d = ARM_IDLE;
        endcase
        if (!en) state_d = ARM_IDLE;
    end

    always_comb armed = (state_q == ARM_READY);
endmodule

// File: rtl/i2c_stat_role.sv
module i2c_stat_role
    import i2c_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic wr_start,
    input  logic ev_stop,
    input  logic ev_arb_lost,
    output logic master
);
    role_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ROLE_SLAVE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ROLE_SLAVE:  if (wr_start) state_d = ROLE_MASTER;
            ROLE_MASTER: if ((ev_stop || ev_arb_lost) && !wr_start) state_d = ROLE_SLAVE;
        endcase
        if (!en) state_d = ROLE_SLAVE;
    end

    always_comb master = (state_q == ROLE_MASTER);
endmodule

// File: rtl/i2c_stat_bank.sv
module i2c_stat_bank
    import i2c_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic ack_en,
    input  logic ev_start_gen,
    input  logic ev_addr_match,
    input  logic ev_gcall_match,
    input  logic ev_byte_tx_done,
    input  logic ev_ack_clk_done,
    input  logic rd_stat,
    input  logic rd_data,
    input  logic wr_data,
    input  logic armed,
    output logic sb,
    output logic adm,
    output logic gcal,
    output logic btf
);
    btf_state_e btf_q, btf_d;
    logic sb_q, sb_d, adm_q, adm_d, gc_q, gc_d;
    logic armed_rd, armed_wr, rx_set, tx_set;

    always_comb begin
        armed_rd = armed && rd_data;
        armed_wr = armed && wr_data;
        rx_set   = ev_ack_clk_done && ack_en;
        tx_set   = ev_byte_tx_done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            btf_q <= BTF_CLEAR;
            sb_q  <= 1'b0;
            adm_q <= 1'b0;
            gc_q  <= 1'b0;
        end else begin
            btf_q <= btf_d;
            sb_q  <= sb_d;
            adm_q <= adm_d;
            gc_q  <= gc_d;
        end
    end

    always_comb begin
        sb_d = sb_q;
        if (ev_start_gen)  sb_d = 1'b1;
        else if (armed_wr) sb_d = 1'b0;

        adm_d = adm_q;
        if (ev_addr_match || ev_gcall_match) adm_d = 1'b1;
        else if (rd_stat)                    adm_d = 1'b0;

        gc_d = gc_q;
        if (ev_gcall_match) gc_d = 1'b1;
        else if (rd_stat)   gc_d = 1'b0;

        btf_d = btf_q;
        if (rx_set)      btf_d = BTF_RX;
        else if (tx_set) btf_d = BTF_TX;
        else begin
            unique case (btf_q)
                BTF_CLEAR: btf_d = BTF_CLEAR;
                BTF_RX:    if (armed_rd) btf_d = BTF_CLEAR;
                BTF_TX:    if (armed_wr) btf_d = BTF_CLEAR;
                default:   btf_d = BTF_CLEAR;
            endcase
        end

        if (!en) begin
            sb_d  = 1'b0;
            adm_d = 1'b0;
            gc_d  = 1'b0;
            btf_d = BTF_CLEAR;
        end
    end

    always_comb begin
        sb   = sb_q;
        adm  = adm_q;
        gcal = gc_q;
        btf  = (btf_q != BTF_CLEAR);
    end
endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags
    import i2c_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              ie,
    input  logic              ack_en,
    input  logic              ev_start_gen,
    input  logic              ev_addr_match,
    input  logic              ev_gcall_match,
    input  logic              ev_byte_tx_done,
    input  logic              ev_ack_clk_done,
    input  logic              ev_stop,
    input  logic              ev_arb_lost,
    input  logic              wr_start,
    input  logic              rd_stat,
    input  logic              rd_data,
    input  logic              wr_data,
    output logic [STAT_W-1:0] stat1,
    output logic [STAT_W-1:0] stat2,
    output logic              irq,
    output logic              scl_hold
);
    logic armed, master, sb, adm, gcal, btf;

    i2c_stat_arm u_arm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .rd_stat  (rd_stat),
        .data_acc (rd_data || wr_data),
        .armed    (armed)
    );

    i2c_stat_role u_role (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .wr_start    (wr_start),
        .ev_stop     (ev_stop),
        .ev_arb_lost (ev_arb_lost),
        .master      (master)
    );

    i2c_stat_bank u_bank (
        .clk             (clk),
        .rst_n           (rst_n),
        .en              (en),
        .ack_en          (ack_en),
        .ev_start_gen    (ev_start_gen),
        .ev_addr_match   (ev_addr_match),
        .ev_gcall_match  (ev_gcall_match),
        .ev_byte_tx_done (ev_byte_tx_done),
        .ev_ack_clk_done (ev_ack_clk_done),
        .rd_stat         (rd_stat),
        .rd_data         (rd_data),
        .wr_data         (wr_data),
        .armed           (armed),
        .sb              (sb),
        .adm             (adm),
        .gcal            (gcal),
        .btf             (btf)
    );

    always_comb begin
        stat1          = '0;
        stat1[SB_BIT]  = sb;
        stat1[MSL_BIT] = master;
        stat1[ADM_BIT] = adm;
        stat1[BTF_BIT] = btf;
        stat2          = '0;
        stat2[GC_BIT]  = gcal;
        irq            = ie && (sb || adm || btf);
        scl_hold       = adm || btf;
    end
endmodule

// File: rtl/i2c_stat_chk.sv
module i2c_stat_chk
    import i2c_stat_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              ev_start_gen,
    input logic              ev_addr_match,
    input logic              ev_gcall_match,
    input logic              wr_start,
    input logic              rd_stat,
    input logic              rd_data,
    input logic              wr_data,
    input logic [STAT_W-1:0] stat1,
    input logic [STAT_W-1:0] stat2
);
    p_disable_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (stat1 == '0 && stat2 == '0));

    p_sb_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ev_start_gen) |=> stat1[SB_BIT]);

    p_sb_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && stat1[SB_BIT] && !wr_data) |=> stat1[SB_BIT]);

    p_master_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr_start) |=> stat1[MSL_BIT]);

    p_adm_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (ev_addr_match || ev_gcall_match)) |=> stat1[ADM_BIT]);

    p_adm_read_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !ev_addr_match && !ev_gcall_match) |=> !stat1[ADM_BIT]);

    p_btf_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && stat1[BTF_BIT] && !rd_data && !wr_data) |=> stat1[BTF_BIT]);

    p_stat2_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        stat2[STAT_W-1:1] == '0);
endmodule

bind i2c_stat_flags i2c_stat_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .en             (en),
    .ev_start_gen   (ev_start_gen),
    .ev_addr_match  (ev_addr_match),
    .ev_gcall_match (ev_gcall_match),
    .wr_start       (wr_start),
    .rd_stat        (rd_stat),
    .rd_data        (rd_data),
    .wr_data        (wr_data),
    .stat1          (stat1),
    .stat2          (stat2)
);

// File: tb/test_i2c_stat_flags.sv
`timescale 1ns/1ps
module test_i2c_stat_flags;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, ie = 1'b0, ack_en = 1'b0;
    logic ev_start_gen = 0, ev_addr_match = 0, ev_gcall_match = 0;
    logic ev_byte_tx_done = 0, ev_ack_clk_done = 0, ev_stop = 0, ev_arb_lost = 0;
    logic wr_start = 0, rd_stat = 0, rd_data = 0, wr_data = 0;
    logic [7:0] stat1, stat2;
    logic irq, scl_hold;
    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    i2c_stat_flags i_i2c_stat_flags (
        .clk(clk), .rst_n(rst_n), .en(en), .ie(ie), .ack_en(ack_en),
        .ev_start_gen(ev_start_gen), .ev_addr_match(ev_addr_match),
        .ev_gcall_match(ev_gcall_match), .ev_byte_tx_done(ev_byte_tx_done),
        .ev_ack_clk_done(ev_ack_clk_done), .ev_stop(ev_stop),
        .ev_arb_lost(ev_arb_lost), .wr_start(wr_start), .rd_stat(rd_stat),
        .rd_data(rd_data), .wr_data(wr_data), .stat1(stat1), .stat2(stat2),
        .irq(irq), .scl_hold(scl_hold)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Apply the strobes set beforehand across one rising edge, sample at the next falling edge.
    task automatic tick();
        @(negedge clk);
        ev_start_gen = 0; ev_addr_match = 0; ev_gcall_match = 0;
        ev_byte_tx_done = 0; ev_ack_clk_done = 0; ev_stop = 0; ev_arb_lost = 0;
        wr_start = 0; rd_stat = 0; rd_data = 0; wr_data = 0;
    endtask

    task automatic t_reset();
        check("R1 stat1", stat1, 8'h00);
        check("R1 stat2", stat2, 8'h00);
        check("R1 irq/hold", {6'd0, irq, scl_hold}, 8'h00);
        check("R12 stat2 hi", {5'd0, stat2[7:5]}, 8'h00);
    endtask

    task automatic t_start();
        ev_start_gen = 1; tick();
        check("R2 sb set", stat1, 8'h01);
        check("R10 irq on sb", {7'd0, irq}, 8'h01);
        check("R11 sb no hold", {7'd0, scl_hold}, 8'h00);
        wr_data = 1; tick();
        check("R2 unarmed write keeps sb", stat1, 8'h01);
        rd_stat = 1; tick();
        wr_data = 1; tick();
        check("R2 armed write clears sb", stat1, 8'h00);
        check("R10 irq drops", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_role();
        wr_start = 1; tick();
        check("R3 master set", stat1, 8'h02);
        check("R10 master no irq", {7'd0, irq}, 8'h00);
        ev_stop = 1; tick();
        check("R3 stop clears master", stat1, 8'h00);
        wr_start = 1; tick();
        ev_arb_lost = 1; tick();
        check("R3 arb lost clears master", stat1, 8'h00);
        wr_start = 1; ev_stop = 1; tick();
        check("R8 start wins over stop", stat1, 8'h02);
        ev_stop = 1; tick();
        check("R3 cleanup", stat1, 8'h00);
    endtask

    task automatic t_addr();
        ev_addr_match = 1; tick();
        check("R4 addr set", stat1, 8'h04);
        check("R4 no gcall", stat2, 8'h00);
        check("R11 addr holds scl", {7'd0, scl_hold}, 8'h01);
        rd_stat = 1; tick();
        check("R4 read clears addr", stat1, 8'h00);
        ev_gcall_match = 1; tick();
        check("R4 gcall sets addr", stat1, 8'h04);
        check("R4 gcall stat2", stat2, 8'h01);
        rd_stat = 1; tick();
        check("R4 read clears gcall", {stat1[7:0] | stat2}, 8'h00);
        ev_addr_match = 1; rd_stat = 1; tick();
        check("R8 match wins over read", stat1, 8'h04);
        rd_stat = 1; tick();
        rd_data = 1; tick();
        check("R4 cleanup", stat1, 8'h00);
    endtask

    task automatic t_btf_rx();
        ack_en = 0; ev_ack_clk_done = 1; tick();
        check("R5 no set without ack_en", stat1, 8'h00);
        ack_en = 1; ev_ack_clk_done = 1; tick();
        check("R5 rx byte done set", stat1, 8'h08);
        check("R11 btf holds scl", {7'd0, scl_hold}, 8'h01);
        check("R10 irq on btf", {7'd0, irq}, 8'h01);
        rd_stat = 1; tick();
        wr_data = 1; tick();
        check("R5 armed write keeps rx btf", stat1, 8'h08);
        rd_data = 1; tick();
        check("R7 consumed latch keeps btf", stat1, 8'h08);
        rd_stat = 1; tick();
        rd_data = 1; tick();
        check("R5 armed read clears rx btf", stat1, 8'h00);
    endtask

    task automatic t_btf_tx();
        ev_byte_tx_done = 1; tick();
        check("R6 tx byte done set", stat1, 8'h08);
        rd_stat = 1; tick();
        rd_data = 1; tick();
        check("R6 armed read keeps tx btf", stat1, 8'h08);
        rd_stat = 1; tick();
        wr_data = 1; tick();
        check("R6 armed write clears tx btf", stat1, 8'h00);
        ev_byte_tx_done = 1; tick();
        rd_stat = 1; tick();
        wr_data = 1; ev_byte_tx_done = 1; tick();
        check("R8 tx done wins over write", stat1, 8'h08);
        rd_stat = 1; tick();
        wr_data = 1; tick();
        check("R6 cleanup", stat1, 8'h00);
    endtask

    task automatic t_disable();
        ev_start_gen = 1; wr_start = 1; ev_addr_match = 1; ev_byte_tx_done = 1; tick();
        check("R9 all set", stat1, 8'h0F);
        rd_stat = 1; tick();
        check("R4 read drops addr only", stat1, 8'h0B);
        en = 0; tick();
        check("R9 disable clears", stat1, 8'h00);
        ev_start_gen = 1; ev_gcall_match = 1; tick();
        check("R9 events ignored stat1", stat1, 8'h00);
        check("R9 events ignored stat2", stat2, 8'h00);
        check("R9 irq off", {7'd0, irq}, 8'h00);
        en = 1; ev_start_gen = 1; tick();
        wr_data = 1; tick();
        check("R9 latch forgotten", stat1, 8'h01);
        ie = 0; tick();
        check("R10 ie gates irq", {7'd0, irq}, 8'h00);
        ie = 1;
        rd_stat = 1; tick();
        wr_data = 1; tick();
        check("R2 final clear", stat1, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        en = 1; ie = 1;
        @(negedge clk);
        t_start();
        t_role();
        t_addr();
        t_btf_rx();
        t_btf_tx();
        t_disable();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule